// File: doc/BRIEF.md
# Handshaked Bit-Serial Byte Sender

This block moves a counted run of bytes to a tape-port peer over two wires. The block owns one line (the data line). The peer owns the other (the peer clock), and its edges pace every bit. Bytes arrive from an upstream FIFO over a valid/ready interface. The transfer length is given as a 16-bit value equal to the byte count minus one. The length sampled on the start pulse stays fixed until the transfer ends.

To open a byte, the block pulls the data line low. The peer then alternates its line, rising first. Each edge the block is watching lets it put the next bit on the data line, least significant bit first. After the eighth bit, one more rising edge raises the data line and closes the byte. When the last byte is closed, the block offers the acknowledge character on a valid/ready output, raises the data line and goes idle.

Back-pressure works as follows. The block accepts a byte only while it is waiting to open a byte and the synchronized peer line is low. An upstream that holds `in_valid` low simply parks the transfer, with the data line high. On the acknowledge output, `ack_valid` stays set with a constant character until `ack_ready` is seen. Nothing on that output blocks the sender. An abort is possible only through reset.

Top module: `tape_bit_sender`

## Requirements
- R1: During and straight after reset, `data_line` is 1 and `busy`, `in_ready` and `ack_valid` are all 0.
- R2: A `start` pulse while idle loads `len_m1` and sets `busy`. A `start` pulse while `busy` has no effect, so the transfer still ends after the length that was loaded first.
- R3: `in_ready` is 1 only while the block waits to open a byte and the synchronized `peer_clk` is 0. A byte accepted (`in_valid` and `in_ready` both 1) drives `data_line` to 0 on the next clock.
- R4: Within a byte, the watched edge of `peer_clk` starts as rising and alternates after each bit. Each watched edge puts the next data bit on `data_line` (1 = high), bit 0 first.
- R5: The ninth watched edge of a byte, which is a rising edge, drives `data_line` to 1 and closes the byte. The falling edge that follows opens nothing unless a byte is offered.
- R6: After `len_m1`+1 bytes are closed, `busy` falls and `ack_valid` rises in the same cycle, with `ack_data` = 0x40. `ack_valid` holds until a cycle with `ack_ready` = 1. A length of 0 sends exactly one byte.
- R7: If no byte is offered when one is due, `data_line` stays 1 and the block waits. If the peer line is high when data arrives, the byte opens only after the peer line has gone low.
- R8: `data_line` reacts to a change on `peer_clk` at the third rising clock edge after the change: two synchronizer flops, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| len_m1 | input | 16 | Byte count minus one |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| peer_clk | input | 1 | Asynchronous pacing line from the peer |
| data_line | output | 1 | Data/request line to the peer |
| busy | output | 1 | Transfer in progress |
| ack_valid | output | 1 | Acknowledge character pending |
| ack_data | output | 8 | Acknowledge character (0x40) |
| ack_ready | input | 1 | Acknowledge taken |

## Verification
A wrong bit counter or edge polarity shows on `data_line` within three clocks of the first edge it mishandles. The peer's reconstructed byte then differs, or the closing level is low. A wrong byte counter shows as `busy` falling and `ack_valid` rising one byte early, or never. A broken handshake condition shows as `in_ready` rising while the peer line is high, or a byte being taken outside the opening slot. The bench compares every output against its reference model on every cycle, so any of these faults is reported at the first cycle where the outputs differ.

// File: rtl/tape_tx_pkg.sv
package tape_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_t;

  localparam logic [7:0] ACK_CHAR_DEFAULT = 8'h40;
endpackage

// File: rtl/tape_edge_sync.sv
module tape_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/tape_bit_shifter.sv
module tape_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         step,
  output logic         bit_out,
  output logic         empty
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= load_data;
      left  <= FULL;
    end else if (step && left != '0) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
    end
  end

  assign bit_out = shreg[0];
  assign empty   = (left == '0);
endmodule

// File: rtl/tape_len_counter.sv
module tape_len_counter #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [LW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remaining <= '0;
    else if (load)  remaining <= load_val;
    else if (dec)   remaining <= remaining - 1'b1;
  end

  assign last = (remaining == '0);
endmodule

// File: rtl/tape_bit_sender.sv
module tape_bit_sender
  import tape_tx_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         LEN_W    = 16,
  parameter int         SYNC_N   = 2,
  parameter logic [7:0] ACK_CHAR = ACK_CHAR_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              peer_clk,
  output logic              data_line,
  output logic              busy,
  output logic              ack_valid,
  output logic [7:0]        ack_data,
  input  logic              ack_ready
);
  tx_state_t state;
  logic      want_rise;
  logic      p_level, p_rise, p_fall;
  logic      bit_now, bits_done, len_last;
  logic      accept, watched, step, close_byte, finish, go;

  tape_edge_sync #(.STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(peer_clk),
    .level(p_level), .rise(p_rise), .fall(p_fall)
  );

  assign go         = (state == ST_IDLE) && start;
  assign in_ready   = (state == ST_WAIT) && !p_level;
  assign accept     = in_valid && in_ready;
  assign watched    = want_rise ? p_rise : p_fall;
  assign step       = (state == ST_SHIFT) && watched && !bits_done;
  assign close_byte = (state == ST_SHIFT) && watched && bits_done;
  assign finish     = close_byte && len_last;

  tape_bit_shifter #(.W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(in_data),
    .step(step), .bit_out(bit_now), .empty(bits_done)
  );

  tape_len_counter #(.LW(LEN_W)) i_len (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(len_m1),
    .dec(close_byte && !len_last), .last(len_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      want_rise <= 1'b1;
      data_line <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          data_line <= 1'b1;
          if (start) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (accept) begin
            data_line <= 1'b0;
            want_rise <= 1'b1;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (step) begin
            data_line <= bit_now;
            want_rise <= ~want_rise;
          end else if (close_byte) begin
            data_line <= 1'b1;
            state     <= finish ? ST_IDLE : ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ack_valid <= 1'b0;
    else if (finish)    ack_valid <= 1'b1;
    else if (ack_ready) ack_valid <= 1'b0;
  end

  assign ack_data = ACK_CHAR;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/tape_tx_checker.sv
module tape_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic data_line,
  input logic busy,
  input logic ack_valid,
  input logic ack_ready
);
  // R1: idle keeps the line high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> data_line);

  // R3: ready only in a busy wait slot, with the line high
  a_r3_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && data_line));

  // R3: a taken byte drops the line
  a_r3_accept_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !data_line);

  // R6: the end of a transfer raises the acknowledge
  a_r6_end_acks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ack_valid);

  // R6: the acknowledge holds until taken
  a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> ack_valid);
endmodule

bind tape_bit_sender tape_tx_checker i_tape_tx_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .data_line(data_line), .busy(busy), .ack_valid(ack_valid),
  .ack_ready(ack_ready)
);

// File: tb/test_tape_bit_sender.sv
`timescale 1ns/1ps
module test_tape_bit_sender;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] len_m1 = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        peer_clk = 1'b0;
  logic        data_line;
  logic        busy;
  logic        ack_valid;
  logic [7:0]  ack_data;
  logic        ack_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit feed_en = 1'b1;
  bit cmp_en  = 1'b0;
  string cur_req = "R3";
  logic [7:0] fifo[$];

  always #5 clk = ~clk;

  tape_bit_sender i_tape_bit_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(len_m1),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .peer_clk(peer_clk), .data_line(data_line), .busy(busy),
    .ack_valid(ack_valid), .ack_data(ack_data), .ack_ready(ack_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 waiting for a byte, 2 sending bits
  int   m_mode = 0;
  int   m_left = 0;
  bit   m_bits[$];
  bit   m_rise = 1;
  bit   m_line = 1, m_ack = 0, m_ready = 0;
  bit   w1 = 0, w2 = 0, wp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_bits.delete(); m_rise = 1;
      m_line = 1; m_ack = 0; m_ready = 0; w1 = 0; w2 = 0; wp = 0;
    end else begin
      bit r, f, hit, take, fin;
      r = w2 && !wp;
      f = !w2 && wp;
      hit = m_rise ? r : f;
      take = (m_mode == 1) && !w2 && in_valid;
      fin = 0;
      case (m_mode)
        0: if (start) begin m_left = len_m1; m_mode = 1; end
        1: if (take) begin
             for (int k = 0; k < 8; k++) m_bits.push_back(in_data[k]);
             void'(fifo.pop_front());
             m_line = 0; m_rise = 1; m_mode = 2;
           end
        default: if (hit) begin
             if (m_bits.size() > 0) begin
               m_line = m_bits.pop_front();
               m_rise = !m_rise;
             end else begin
               m_line = 1;
               if (m_left == 0) begin fin = 1; m_mode = 0; end
               else begin m_left--; m_mode = 1; end
             end
           end
      endcase
      if (fin) m_ack = 1;
      else if (ack_ready) m_ack = 0;
      wp = w2; w2 = w1; w1 = peer_clk;
      m_ready = (m_mode == 1) && !w2;
    end
  end

  // drive the FIFO side and compare every cycle
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(data_line === m_line, cur_req, "data_line", data_line, m_line);
      chk(in_ready === m_ready, cur_req, "in_ready", in_ready, m_ready);
      chk(busy === (m_mode != 0), cur_req, "busy", busy, m_mode != 0);
      chk(ack_valid === m_ack, "R6", "ack_valid", ack_valid, m_ack);
      if (ack_valid)
        chk(ack_data === 8'h40, "R6", "ack_data", ack_data, 8'h40);
    end
    in_valid = feed_en && (fifo.size() > 0);
    in_data  = (fifo.size() > 0) ? fifo[0] : 8'h00;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] len);
    @(negedge clk);
    len_m1 = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic peer_byte(input logic [7:0] exp);
    logic [7:0] got;
    int t;
    t = 0;
    while (data_line !== 1'b0 && t < 60) begin @(negedge clk); t++; end
    chk(data_line === 1'b0, "R3", "byte opened with line low", data_line, 0);
    for (int k = 0; k < 8; k++) begin
      cur_req = "R4";
      @(negedge clk); peer_clk = ~peer_clk;
      cyc(2);
      if (k == 0) chk(data_line === 1'b0, "R8", "line before 3rd edge", data_line, 0);
      @(negedge clk);
      got[k] = data_line;
      if (k == 0) chk(data_line === exp[0], "R8", "line at 3rd edge", data_line, exp[0]);
      cyc(1);
    end
    chk(got === exp, "R4", "byte seen by peer", got, exp);
    cur_req = "R5";
    @(negedge clk); peer_clk = 1'b1;
    cyc(4);
    chk(data_line === 1'b1, "R5", "line after closing edge", data_line, 1);
    @(negedge clk); peer_clk = 1'b0;
    cyc(4);
    cur_req = "R3";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk(data_line === 1'b1, "R1", "reset data_line", data_line, 1);
    chk(busy === 1'b0, "R1", "reset busy", busy, 0);
    chk(in_ready === 1'b0, "R1", "reset in_ready", in_ready, 0);
    chk(ack_valid === 1'b0, "R1", "reset ack_valid", ack_valid, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc(3);

    // two bytes, FIFO preloaded, acknowledge held before it is taken
    fifo.push_back(8'hA5); fifo.push_back(8'h3C);
    pulse_start(16'd1);
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    peer_byte(8'hA5);
    chk(busy === 1'b1, "R6", "busy between bytes", busy, 1);
    peer_byte(8'h3C);
    chk(ack_valid === 1'b1 && busy === 1'b0, "R6", "ack after last byte",
        {ack_valid, busy}, 2'b10);
    cyc(5);
    chk(ack_valid === 1'b1, "R6", "ack held without ready", ack_valid, 1);
    @(negedge clk); ack_ready = 1'b1;
    @(negedge clk); ack_ready = 1'b0;
    chk(ack_valid === 1'b0, "R6", "ack cleared by ready", ack_valid, 0);

    // length 0 with empty FIFO, pause, and ignored second start
    pulse_start(16'd0);
    cur_req = "R7";
    cyc(6);
    chk(data_line === 1'b1 && in_ready === 1'b1, "R7", "parked with no data",
        {data_line, in_ready}, 2'b11);
    @(negedge clk); peer_clk = 1'b1;
    cyc(4);
    fifo.push_back(8'h81);
    cyc(10);
    chk(in_ready === 1'b0 && data_line === 1'b1, "R7", "no open while peer high",
        {in_ready, data_line}, 2'b01);
    pulse_start(16'd5);
    @(negedge clk); peer_clk = 1'b0;
    peer_byte(8'h81);
    chk(busy === 1'b0, "R2", "second start ignored, one byte only", busy, 0);
    chk(ack_valid === 1'b1, "R6", "ack after single byte", ack_valid, 1);

    // three bytes with the acknowledge taken at once
    ack_ready = 1'b1;
    fifo.push_back(8'h00); fifo.push_back(8'hFF); fifo.push_back(8'h5A);
    pulse_start(16'd2);
    peer_byte(8'h00);
    peer_byte(8'hFF);
    peer_byte(8'h5A);
    chk(busy === 1'b0 && data_line === 1'b1, "R6", "idle after three bytes",
        {busy, data_line}, 2'b01);
    cyc(4);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule